// File: doc/BRIEF.md
# Nested Priority Exception Sequencer

This block decides which interrupt request a small processor core services next, and walks the core through entering and leaving that service. Each request line has a programmable urgency level. The block latches requests into sticky pending bits and picks the most urgent one. It then runs a timed context-save phase, presents the handler start address from its own vector table while the handler runs, and runs a timed context-restore phase when the handler reports completion.

A more urgent request can interrupt a running handler. The interrupted context is pushed onto a bounded nesting stack and restored later. The sequencer can also change course partway through a phase:
- A handler that finishes while a sufficiently urgent request waits moves straight to the next handler, with no restore.
- A more urgent request that arrives during a save takes over the save.
- A sufficiently urgent request that arrives during a restore cancels the restore.

Priority levels and vector table slots load through a single write port.

Top module: `nest_exc_seq`

## Requirements
- R1: After reset the phase is idle (0), `active_prio` equals 2^PRIO_W (thread level, least urgent), `nest_level` is 0, `pending` is all zero, `handler_addr` is 0 and every vector slot reads 0.
- R2: A write with `cfg_is_vec`=1 stores `cfg_data` into vector slot `cfg_idx`. Slot 0 is the reset address and appears on `boot_addr`. While line i is in service, `handler_addr` shows slot i+1. With `cfg_is_vec`=0, a write sets the priority of line `cfg_idx` to `cfg_data[PRIO_W-1:0]`.
- R3: `seq_phase` encodes idle=0, save=1, active=2, restore=3. Every save phase lasts exactly PHASE_CYC cycles and is followed by the active phase.
- R4: Among pending lines, the lowest priority value wins. Between equal values, the lowest line index wins.
- R5: A pending bit is set by a high request line and stays set until that line's handler is entered, at which point it clears. Several pulses before entry produce a single service.
- R6: A pending request preempts the active handler only when its priority value is strictly lower. Preemption starts a save phase and raises `nest_level` by one. An equal value never preempts.
- R7: When `handler_done` is asserted and a pending request is more urgent than the level being returned to, the next cycle is active with the new line and no restore phase (tail chaining).
- R8: If a request more urgent than the current save target arrives during a save, the save continues without restarting. The more urgent line is entered at its end, and the displaced line stays pending.
- R9: During a restore, a pending request more urgent than the level being returned to cancels the restore in the next cycle and enters that line's handler.
- R10: `nest_level` never exceeds NEST_DEPTH. A preemption that would exceed it is held pending while the active handler keeps running.
- R11: A restore lasts PHASE_CYC cycles. It then resumes the preempted handler with `nest_level` lowered by one, or, if nothing was preempted, returns to idle with `active_prio` at thread level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_IRQ | Request lines, sampled each cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_vec | input | 1 | 1: vector slot write, 0: priority write |
| cfg_idx | input | clog2(NUM_IRQ+1) | Slot or line index |
| cfg_data | input | ADDR_W | Write data |
| handler_done | input | 1 | Active handler has finished |
| seq_phase | output | 2 | Current phase (0 idle, 1 save, 2 active, 3 restore) |
| handler_addr | output | ADDR_W | Handler start address while active, else 0 |
| boot_addr | output | ADDR_W | Contents of vector slot 0 |
| active_irq | output | clog2(NUM_IRQ) | Line currently in service |
| active_prio | output | PRIO_W+1 | Running priority level (2^PRIO_W at thread level) |
| nest_level | output | clog2(NEST_DEPTH+1) | Number of preempted handlers saved |
| pending | output | NUM_IRQ | Sticky pending bits |

## Verification
The bench checks several redirect cases.
- A request that lands in the middle of a save. A design that restarted the save would show more than PHASE_CYC save cycles. One that ignored the request would enter the less urgent line.
- A request that arrives during a restore. A design that failed to cancel would finish all PHASE_CYC restore cycles.
- A completion with work still waiting. A design without tail chaining would pass through a restore phase first.
- Ties. Two equal-priority lines test the index tie-break, and an equal-priority request arriving during a handler must not nest.
- A full nesting stack. The extra request must stay pending rather than push a fifth saved context, and must later enter by tail chaining.
- Merging. Repeated pulses on one line must produce a single service.

// File: rtl/nes_pkg.sv
// Package: shared phase encoding for the nested exception sequencer.
// Assumes a 2-bit phase output whose code values are visible at the ports.
package nes_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STACK   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_UNSTACK = 2'd3
    } nes_phase_e;
endpackage

// File: rtl/nes_cfg_regs.sv
// Module: per-line priority registers and the handler vector table.
// Slot 0 of the table is the reset address; slot i+1 belongs to line i.
// Assumes a single write port; no read-back path beyond the two read outputs.
module nes_cfg_regs #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 16,
    parameter int SLOT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        is_vec,
    input  logic [SLOT_W-1:0]           idx,
    input  logic [ADDR_W-1:0]           wdata,
    input  logic [SLOT_W-1:0]           rd_slot,
    output logic [NUM_IRQ*PRIO_W-1:0]   prio_flat,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic [ADDR_W-1:0]           boot_addr
);
    logic [ADDR_W-1:0] vec_q [NUM_IRQ+1];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        logic [PRIO_W-1:0] p_q;
        // Holds the programmed urgency of line i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                p_q <= '0;
            else if (we && !is_vec && idx == SLOT_W'(i))
                p_q <= wdata[PRIO_W-1:0];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = p_q;
    end

    for (genvar s = 0; s <= NUM_IRQ; s++) begin : g_vec
        // Holds the handler start address of slot s.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec_q[s] <= '0;
            else if (we && is_vec && idx == SLOT_W'(s))
                vec_q[s] <= wdata;
        end
    end

    // Reads the table for the active handler and for the reset slot.
    always_comb begin
        rd_addr = '0;
        for (int s = 0; s <= NUM_IRQ; s++)
            if (rd_slot == SLOT_W'(s)) rd_addr = vec_q[s];
        boot_addr = vec_q[0];
    end
endmodule

// File: rtl/nes_arbiter.sv
// Module: combinational picker of the most urgent pending line.
// Lower priority value is more urgent; ties go to the lower line index.
module nes_arbiter #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      best_vld,
    output logic [IDX_W-1:0]          best_idx,
    output logic [PRIO_W-1:0]         best_prio
);
    // Scans upward; a strict compare keeps the lower index on a tie.
    always_comb begin
        best_vld  = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!best_vld || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
                best_vld  = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/nes_nest_stack.sv
// Module: bounded LIFO of preempted handler contexts.
// Assumes DEPTH >= 2 and that the caller never pushes when full or pops when empty.
module nes_nest_stack #(
    parameter int DEPTH = 4,
    parameter int EW    = 7,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [EW-1:0]    push_data,
    output logic [EW-1:0]    top_data,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [EW-1:0]    mem_q [DEPTH];
    logic [LVL_W-1:0] lvl_q;

    // Tracks how many contexts are saved.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else if (push && !full)
            lvl_q <= lvl_q + LVL_W'(1);
        else if (pop && lvl_q != '0)
            lvl_q <= lvl_q - LVL_W'(1);
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        // Stores the context written when the fill level equals e.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[e] <= '0;
            else if (push && !full && lvl_q == LVL_W'(e))
                mem_q[e] <= push_data;
        end
    end

    assign level    = lvl_q;
    assign full     = (lvl_q == LVL_W'(DEPTH));
    assign top_data = (lvl_q == '0) ? '0 : mem_q[AW'(lvl_q - LVL_W'(1))];
endmodule

// File: rtl/nest_exc_seq.sv
// Module: top of the nested priority exception sequencer.
// Latches requests, arbitrates, and sequences save / active / restore phases
// with preemption, tail chaining, late-arrival retarget and restore cancel.
// Assumes PHASE_CYC >= 2, NEST_DEPTH >= 2, synchronous active-low reset.
module nest_exc_seq
    import nes_pkg::*;
#(
    parameter int NUM_IRQ    = 8,
    parameter int PRIO_W     = 3,
    parameter int ADDR_W     = 16,
    parameter int PHASE_CYC  = 8,
    parameter int NEST_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_IRQ-1:0]                irq_req,
    input  logic                              cfg_we,
    input  logic                              cfg_is_vec,
    input  logic [$clog2(NUM_IRQ+1)-1:0]      cfg_idx,
    input  logic [ADDR_W-1:0]                 cfg_data,
    input  logic                              handler_done,
    output logic [1:0]                        seq_phase,
    output logic [ADDR_W-1:0]                 handler_addr,
    output logic [ADDR_W-1:0]                 boot_addr,
    output logic [$clog2(NUM_IRQ)-1:0]        active_irq,
    output logic [PRIO_W:0]                   active_prio,
    output logic [$clog2(NEST_DEPTH+1)-1:0]   nest_level,
    output logic [NUM_IRQ-1:0]                pending
);
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int SLOT_W = $clog2(NUM_IRQ+1);
    localparam int LVL_W  = $clog2(NEST_DEPTH+1);
    localparam int CNT_W  = $clog2(PHASE_CYC);
    localparam int EW     = IDX_W + PRIO_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);
    localparam logic [PRIO_W:0]  BASE = {1'b1, {PRIO_W{1'b0}}};

    nes_phase_e         ph_q, ph_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [IDX_W-1:0]   tgt_idx_q, tgt_idx_d, cur_idx_q, cur_idx_d, ent_idx;
    logic [PRIO_W:0]    tgt_prio_q, tgt_prio_d, cur_prio_q, cur_prio_d;
    logic [NUM_IRQ-1:0] pend_q, clr_vec;
    logic               enter, push, pop;

    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [ADDR_W-1:0]         rd_addr;
    logic                      best_vld;
    logic [IDX_W-1:0]          best_idx;
    logic [PRIO_W-1:0]         best_prio;
    logic [PRIO_W:0]           best_p, ret_prio;
    logic [EW-1:0]             top_data;
    logic [LVL_W-1:0]          level;
    logic                      stk_full;

    nes_cfg_regs #(
        .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .is_vec(cfg_is_vec),
        .idx(cfg_idx), .wdata(cfg_data),
        .rd_slot(SLOT_W'(cur_idx_q) + SLOT_W'(1)),
        .prio_flat(prio_flat), .rd_addr(rd_addr), .boot_addr(boot_addr)
    );

    nes_arbiter #(
        .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_arb (
        .pend(pend_q), .prio_flat(prio_flat),
        .best_vld(best_vld), .best_idx(best_idx), .best_prio(best_prio)
    );

    nes_nest_stack #(
        .DEPTH(NEST_DEPTH), .EW(EW), .LVL_W(LVL_W)
    ) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data({cur_idx_q, cur_prio_q}),
        .top_data(top_data), .level(level), .full(stk_full)
    );

    assign best_p   = {1'b0, best_prio};
    assign ret_prio = (level == '0) ? BASE : top_data[PRIO_W:0];

    // Computes the next phase, target and running context.
    always_comb begin
        ph_d       = ph_q;
        cnt_d      = cnt_q;
        tgt_idx_d  = tgt_idx_q;
        tgt_prio_d = tgt_prio_q;
        cur_idx_d  = cur_idx_q;
        cur_prio_d = cur_prio_q;
        enter      = 1'b0;
        ent_idx    = tgt_idx_q;
        push       = 1'b0;
        pop        = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (best_vld) begin
                    ph_d       = PH_STACK;
                    cnt_d      = '0;
                    tgt_idx_d  = best_idx;
                    tgt_prio_d = best_p;
                end
            end
            PH_STACK: begin
                if (best_vld && best_p < tgt_prio_q) begin
                    tgt_idx_d  = best_idx;
                    tgt_prio_d = best_p;
                end
                if (cnt_q == LAST) begin
                    ph_d       = PH_ACTIVE;
                    enter      = 1'b1;
                    ent_idx    = tgt_idx_d;
                    cur_idx_d  = tgt_idx_d;
                    cur_prio_d = tgt_prio_d;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (handler_done) begin
                    if (best_vld && best_p < ret_prio) begin
                        enter      = 1'b1;
                        ent_idx    = best_idx;
                        cur_idx_d  = best_idx;
                        cur_prio_d = best_p;
                    end else begin
                        ph_d  = PH_UNSTACK;
                        cnt_d = '0;
                    end
                end else if (best_vld && best_p < cur_prio_q && !stk_full) begin
                    push       = 1'b1;
                    ph_d       = PH_STACK;
                    cnt_d      = '0;
                    tgt_idx_d  = best_idx;
                    tgt_prio_d = best_p;
                end
            end
            PH_UNSTACK: begin
                if (best_vld && best_p < ret_prio) begin
                    ph_d       = PH_ACTIVE;
                    enter      = 1'b1;
                    ent_idx    = best_idx;
                    cur_idx_d  = best_idx;
                    cur_prio_d = best_p;
                end else if (cnt_q == LAST) begin
                    if (level != '0) begin
                        pop        = 1'b1;
                        ph_d       = PH_ACTIVE;
                        cur_idx_d  = top_data[EW-1 -: IDX_W];
                        cur_prio_d = top_data[PRIO_W:0];
                    end else begin
                        ph_d       = PH_IDLE;
                        cur_idx_d  = '0;
                        cur_prio_d = BASE;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    // Builds the one-hot clear for the line whose handler is being entered.
    always_comb begin
        clr_vec = '0;
        for (int i = 0; i < NUM_IRQ; i++)
            if (enter && ent_idx == IDX_W'(i)) clr_vec[i] = 1'b1;
    end

    // Registers phase, counter, target and running context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            cnt_q      <= '0;
            tgt_idx_q  <= '0;
            tgt_prio_q <= BASE;
            cur_idx_q  <= '0;
            cur_prio_q <= BASE;
        end else begin
            ph_q       <= ph_d;
            cnt_q      <= cnt_d;
            tgt_idx_q  <= tgt_idx_d;
            tgt_prio_q <= tgt_prio_d;
            cur_idx_q  <= cur_idx_d;
            cur_prio_q <= cur_prio_d;
        end
    end

    // Captures requests into sticky pending bits; entry clears win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q | irq_req) & ~clr_vec;
    end

    assign seq_phase    = ph_q;
    assign handler_addr = (ph_q == PH_ACTIVE) ? rd_addr : '0;
    assign active_irq   = cur_idx_q;
    assign active_prio  = cur_prio_q;
    assign nest_level   = level;
    assign pending      = pend_q;
endmodule

// File: rtl/nes_checker.sv
// Module: temporal checks on the sequencer's ports, bound to the top.
// Assumes the phase encoding of nes_pkg.
module nes_checker #(
    parameter int NUM_IRQ    = 8,
    parameter int PRIO_W     = 3,
    parameter int PHASE_CYC  = 8,
    parameter int NEST_DEPTH = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [1:0]                       seq_phase,
    input logic                             handler_done,
    input logic [$clog2(NUM_IRQ)-1:0]       active_irq,
    input logic [PRIO_W:0]                  active_prio,
    input logic [$clog2(NEST_DEPTH+1)-1:0]  nest_level,
    input logic [NUM_IRQ-1:0]               pending
);
    localparam logic [PRIO_W:0] BASE = {1'b1, {PRIO_W{1'b0}}};
    localparam int RUN_W = $clog2(PHASE_CYC + 2);

    logic [RUN_W-1:0] run_q;

    // Counts consecutive save-phase cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (seq_phase == 2'd1)
            run_q <= run_q + RUN_W'(1);
        else
            run_q <= '0;
    end

    a_r3_stack_not_long: assert property (@(posedge clk) disable iff (!rst_n)
        seq_phase == 2'd1 |-> run_q < RUN_W'(PHASE_CYC));

    a_r3_stack_full_len: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase != 2'd1 && $past(seq_phase) == 2'd1) |-> run_q == RUN_W'(PHASE_CYC));

    a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_phase) == 2'd0 |-> (seq_phase == 2'd0 || seq_phase == 2'd1));

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        nest_level <= NEST_DEPTH);

    a_r11_idle_base: assert property (@(posedge clk) disable iff (!rst_n)
        seq_phase == 2'd0 |-> (active_prio == BASE && nest_level == '0));

    a_r5_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd2 && $past(seq_phase) == 2'd1) |-> !pending[active_irq]);

    a_r7_chain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd2 && $past(seq_phase) == 2'd2 && $past(handler_done))
        |-> !pending[active_irq]);

    a_r6_push_on_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd1 && $past(seq_phase) == 2'd2)
        |-> nest_level == $past(nest_level) + 1'b1);

    a_r6_active_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        seq_phase == 2'd2 |-> active_prio < BASE);
endmodule

bind nest_exc_seq nes_checker #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .PHASE_CYC(PHASE_CYC), .NEST_DEPTH(NEST_DEPTH)
) u_nes_chk (
    .clk(clk), .rst_n(rst_n), .seq_phase(seq_phase), .handler_done(handler_done),
    .active_irq(active_irq), .active_prio(active_prio),
    .nest_level(nest_level), .pending(pending)
);

// File: tb/nest_exc_seq_tb_top.sv
// Bench: directed scenarios for the nested exception sequencer, one task each.
module nest_exc_seq_tb_top;
    localparam int N   = 8;
    localparam int PW  = 3;
    localparam int AW  = 16;
    localparam int PC  = 8;
    localparam int ND  = 4;
    localparam int SW  = $clog2(N+1);
    localparam int TH  = 8;   // thread level 2^PW

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          cfg_we = 1'b0, cfg_is_vec = 1'b0, handler_done = 1'b0;
    logic [SW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [1:0]    seq_phase;
    logic [AW-1:0] handler_addr, boot_addr;
    logic [2:0]    active_irq;
    logic [PW:0]   active_prio;
    logic [2:0]    nest_level;
    logic [N-1:0]  pending;

    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    nest_exc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_is_vec(cfg_is_vec), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .handler_done(handler_done), .seq_phase(seq_phase),
        .handler_addr(handler_addr), .boot_addr(boot_addr),
        .active_irq(active_irq), .active_prio(active_prio),
        .nest_level(nest_level), .pending(pending)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [AW-1:0] vec_of(input int s);
        return AW'(16'h1000 + s * 16'h40);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic isv, input int idx, input int val);
        cfg_we = 1'b1; cfg_is_vec = isv; cfg_idx = SW'(idx); cfg_data = AW'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int line);
        irq_req[line] = 1'b1;
        tick();
        irq_req[line] = 1'b0;
    endtask

    task automatic done_pulse();
        handler_done = 1'b1;
        tick();
        handler_done = 1'b0;
    endtask

    task automatic wait_phase(input int ph);
        for (int k = 0; k < 300 && seq_phase != 2'(ph); k++) tick();
    endtask

    task automatic count_phase(input int ph, output int n);
        n = 0;
        while (seq_phase == 2'(ph) && n < 300) begin n++; tick(); end
    endtask

    task automatic set_prios(input int p0, p1, p2, p3, p4, p5, p6, p7);
        wr(1'b0, 0, p0); wr(1'b0, 1, p1); wr(1'b0, 2, p2); wr(1'b0, 3, p3);
        wr(1'b0, 4, p4); wr(1'b0, 5, p5); wr(1'b0, 6, p6); wr(1'b0, 7, p7);
    endtask

    // R1: reset state at the ports.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 phase", seq_phase, 0);
        chk("R1 active_prio", active_prio, TH);
        chk("R1 nest_level", nest_level, 0);
        chk("R1 pending", pending, 0);
        chk("R1 handler_addr", handler_addr, 0);
        chk("R1 boot_addr", boot_addr, 0);
    endtask

    // R2, R3, R11: single request, table lookup, phase lengths.
    task automatic t_basic();
        int n;
        for (int s = 0; s <= N; s++) wr(1'b1, s, vec_of(s));
        chk("R2 boot slot0", boot_addr, vec_of(0));
        set_prios(7, 7, 7, 4, 7, 7, 7, 7);
        pulse(3);
        chk("R5 pending set", pending, 8'h08);
        wait_phase(1);
        count_phase(1, n);
        chk("R3 save length", n, PC);
        chk("R3 active phase", seq_phase, 2);
        chk("R2 handler addr", handler_addr, vec_of(4));
        chk("R2 active line", active_irq, 3);
        chk("R5 cleared on entry", pending, 0);
        done_pulse();
        count_phase(3, n);
        chk("R11 restore length", n, PC);
        chk("R11 back to idle", seq_phase, 0);
        chk("R11 thread level", active_prio, TH);
    endtask

    // R4, R7: simultaneous requests with a tie, then tail chaining.
    task automatic t_arb_chain();
        set_prios(7, 7, 2, 7, 7, 2, 3, 7);
        irq_req = 8'b0110_0100;
        tick();
        irq_req = '0;
        wait_phase(2);
        chk("R4 tie to lower index", active_irq, 2);
        done_pulse();
        chk("R7 chain no restore", seq_phase, 2);
        chk("R7 chain line", active_irq, 5);
        done_pulse();
        chk("R4 next urgency", active_irq, 6);
        done_pulse();
        chk("R11 restore when empty", seq_phase, 3);
        wait_phase(0);
        chk("R5 all serviced", pending, 0);
    endtask

    // R5: repeated pulses merge into one service.
    task automatic t_merge();
        set_prios(0, 7, 7, 7, 5, 7, 7, 7);
        pulse(0);
        wait_phase(2);
        pulse(4); tick(); pulse(4); pulse(4);
        chk("R5 one pending bit", pending, 8'h10);
        done_pulse();
        chk("R5 merged line entered", active_irq, 4);
        chk("R5 entered once (pending)", pending, 0);
        done_pulse();
        chk("R5 no second service", seq_phase, 3);
        wait_phase(0);
    endtask

    // R6, R11: equal priority holds off, stricter preempts and later returns.
    task automatic t_preempt();
        int n;
        set_prios(7, 1, 7, 7, 5, 7, 7, 5);
        pulse(4);
        wait_phase(2);
        pulse(7);
        repeat (10) tick();
        chk("R6 equal no preempt phase", seq_phase, 2);
        chk("R6 equal no preempt line", active_irq, 4);
        chk("R6 equal stays pending", pending, 8'h80);
        pulse(1);
        tick();
        chk("R6 preempt save", seq_phase, 1);
        chk("R6 nest raised", nest_level, 1);
        wait_phase(2);
        chk("R6 preempting line", active_irq, 1);
        done_pulse();
        count_phase(3, n);
        chk("R11 restore before resume", n, PC);
        chk("R11 resumed line", active_irq, 4);
        chk("R11 nest lowered", nest_level, 0);
        done_pulse();
        chk("R7 chain to equal line", active_irq, 7);
        done_pulse();
        wait_phase(0);
    endtask

    // R8: late arrival during save.
    task automatic t_late();
        int n;
        set_prios(7, 1, 7, 7, 7, 7, 6, 7);
        pulse(6);
        wait_phase(1);
        n = 0;
        while (seq_phase == 2'd1 && n < 50) begin
            n++;
            if (n == 3) irq_req[1] = 1'b1;
            tick();
            irq_req[1] = 1'b0;
        end
        chk("R8 save not restarted", n, PC);
        chk("R8 urgent line first", active_irq, 1);
        chk("R8 displaced stays pending", pending, 8'h40);
        done_pulse();
        chk("R8 displaced next", active_irq, 6);
        done_pulse();
        wait_phase(0);
    endtask

    // R9: restore cancelled by a new request.
    task automatic t_abandon();
        set_prios(7, 7, 7, 4, 7, 6, 7, 7);
        pulse(3);
        wait_phase(2);
        done_pulse();
        chk("R9 restore started", seq_phase, 3);
        tick();
        pulse(5);
        chk("R9 still restoring", seq_phase, 3);
        tick();
        chk("R9 restore cancelled", seq_phase, 2);
        chk("R9 new line", active_irq, 5);
        done_pulse();
        wait_phase(0);
    endtask

    // R10: nest overflow held pending, then entered by tail chain.
    task automatic t_overflow();
        set_prios(7, 7, 1, 2, 3, 4, 5, 6);
        for (int l = 7; l >= 3; l--) begin
            pulse(l);
            wait_phase(1);
            wait_phase(2);
        end
        chk("R10 depth full", nest_level, ND);
        chk("R10 deepest line", active_irq, 3);
        pulse(2);
        repeat (12) tick();
        chk("R10 held phase", seq_phase, 2);
        chk("R10 held line", active_irq, 3);
        chk("R10 held pending", pending, 8'h04);
        chk("R10 depth bound", nest_level, ND);
        done_pulse();
        chk("R7 chain held line", active_irq, 2);
        for (int k = 0; k < ND; k++) begin
            done_pulse();
            wait_phase(2);
        end
        chk("R11 outermost resumed", active_irq, 7);
        done_pulse();
        wait_phase(0);
        chk("R11 final thread level", active_prio, TH);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_arb_chain();
        t_merge();
        t_preempt();
        t_late();
        t_abandon();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule